// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a non-blocking data cache placed between a processor and a request/response memory. Storage is organised as sets of two ways. Each way keeps a valid flag, a dirty flag, a tag and a full data line, and each set keeps a one-bit least-recently-used pointer. The processor presents one word-addressed request at a time and learns in the same cycle whether it was taken. A response port, sampled every cycle, carries an optional data word. Toward memory the cache enqueues whole-line loads and stores when the memory signals room, and takes back load responses in order.

Every cycle the controller picks exactly one action from a fixed priority: HIT (serve the presented request from the arrays), EVICT (write a dirty victim back and reject the request), ISSUE (accept a clean miss, record it in the miss queue and send a line load), FILL (retire the oldest miss with the memory's line) or IDLE. The transitions follow from the inputs alone: a request that hits goes to HIT; a miss with a dirty victim goes to EVICT when memory has room; a miss with a clean victim goes to ISSUE when memory and the miss queue have room; otherwise a waiting memory response with a recorded miss goes to FILL. A rejected request is simply presented again by the processor. After an eviction the retried request finds an invalid way and turns into ISSUE.

Top module: `wb2way_cache`

## Requirements
- R1: After reset every line is invalid and every LRU bit is zero; while reset is held and no request is present, `cpu_resp_valid`, `mem_req_valid` and `mem_resp_take` stay low, and the first load to any address is a miss.
- R2: A request whose set holds a valid way with a matching tag is accepted in the same cycle with no memory request, even when `mem_req_ready` is low; a load hit drives `cpu_resp_valid` with the stored word in that cycle.
- R3: A store hit is accepted with no response; it writes the word into the line and marks it dirty, so a later load returns the new word and a later eviction carries it to memory.
- R4: A miss whose victim is clean is accepted only when `mem_req_ready` is high and the miss queue has room; it then drives a line load (`mem_req_write` low) whose address has the request's tag and index with offset bits zero. Address fields: offset in the low `OFF_W` bits, index in the next `IDX_W` bits, tag in the remaining upper bits.
- R5: A miss whose victim is valid and dirty is rejected; when `mem_req_ready` is high the victim line is written to memory (`mem_req_write` high) at its stored tag, the set index and offset zero, and the victim is invalidated, so the retry of the same request in the next cycle is accepted as a clean miss.
- R6: The victim is way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the way named by the set's LRU bit.
- R7: A hit in way i sets the set's LRU bit to 1-i; an accepted miss inverts it; an eviction leaves it unchanged.
- R8: When `mem_resp_valid` is high and a miss is recorded, the cache takes the response (`mem_resp_take`) and writes the line, valid, into the recorded way and set; a load miss leaves it clean, a store miss merges the store word at its offset and marks it dirty.
- R9: A load-miss fill drives `cpu_resp_valid` with the requested word; a store-miss fill and the EVICT and ISSUE actions drive no response.
- R10: Only one action happens per cycle, in priority HIT, EVICT, ISSUE, FILL; a waiting memory response is not taken in a cycle that serves a hit or sends a memory request.
- R11: The miss queue holds `MQ_DEPTH` (default 2) outstanding misses; a further clean miss is rejected until a fill frees an entry, and fills retire misses in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor presents a request |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | WORD_W | Store data |
| cpu_req_accept | output | 1 | Request taken this cycle |
| cpu_resp_valid | output | 1 | Response word valid this cycle |
| cpu_resp_data | output | WORD_W | Response word |
| mem_req_valid | output | 1 | Enqueue a memory request this cycle |
| mem_req_write | output | 1 | 1 = line store (writeback), 0 = line load |
| mem_req_addr | output | ADDR_W | Line-aligned word address |
| mem_req_line | output | WORD_W*2^OFF_W | Writeback line data |
| mem_req_ready | input | 1 | Memory request path not full |
| mem_resp_valid | input | 1 | Memory response present |
| mem_resp_line | input | WORD_W*2^OFF_W | Memory response line |
| mem_resp_take | output | 1 | Dequeue the memory response this cycle |

## Verification
The assertions assume the memory returns exactly one response per line load, in order, and never raises `mem_resp_valid` without an outstanding load; they also assume no second miss is sent to a set whose earlier miss has not been filled, since the victim way is fixed at issue. The stimulus honours both: the bench memory answers each load once, a few cycles later, from an in-order queue, and every miss sequence waits for earlier misses to the same set to fill before touching that set again, while misses that overlap use distinct sets.

// File: rtl/wb2way_pkg.sv
package wb2way_pkg;

    // One action per cycle, listed in priority order after IDLE
    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_HIT,
        ACT_EVICT,
        ACT_ISSUE,
        ACT_FILL
    } act_e;

endpackage

// File: rtl/wb2way_missq.sv
module wb2way_missq #(
    parameter int DEPTH = 2,
    parameter int ENT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [ENT_W-1:0] push_data,
    input  logic             pop,
    output logic [ENT_W-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ENT_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;

    assign full  = (cnt == CNT_W'(DEPTH));
    assign empty = (cnt == '0);
    assign head  = slots[rd_ptr];

    function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= advance(wr_ptr);
            if (pop)  rd_ptr <= advance(rd_ptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/wb2way_store.sv
module wb2way_store
    import wb2way_pkg::*;
#(
    parameter int TAG_W  = 7,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 2,
    parameter int WORD_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    // lookup of the presented request
    input  logic [TAG_W-1:0]            lk_tag,
    input  logic [IDX_W-1:0]            lk_idx,
    input  logic [OFF_W-1:0]            lk_off,
    output logic                        lk_hit,
    output logic                        lk_way,
    output logic [WORD_W-1:0]           lk_word,
    output logic                        vic_way,
    output logic                        vic_dirty,
    output logic [TAG_W-1:0]            vic_tag,
    output logic [(WORD_W<<OFF_W)-1:0]  vic_line,
    // update commands
    input  act_e                        act,
    input  logic                        wr_en,
    input  logic [WORD_W-1:0]           wr_data,
    input  logic                        fl_way,
    input  logic [IDX_W-1:0]            fl_idx,
    input  logic [TAG_W-1:0]            fl_tag,
    input  logic [(WORD_W<<OFF_W)-1:0]  fl_line,
    input  logic                        fl_dirty
);
    localparam int SETS   = 1 << IDX_W;
    localparam int NWAY   = 2;
    localparam int LINE_W = WORD_W << OFF_W;

    logic [SETS-1:0]   vld [NWAY];
    logic [SETS-1:0]   dty [NWAY];
    logic [SETS-1:0]   lru;
    logic [TAG_W-1:0]  tags  [NWAY][SETS];
    logic [LINE_W-1:0] lines [NWAY][SETS];

    logic [NWAY-1:0]   hit_vec;

    // parallel tag compare, one comparator per way
    for (genvar w = 0; w < NWAY; w++) begin : g_cmp
        assign hit_vec[w] = vld[w][lk_idx] && (tags[w][lk_idx] == lk_tag);
    end

    always_comb begin
        lk_hit  = |hit_vec;
        lk_way  = hit_vec[1];
        lk_word = lines[lk_way][lk_idx][lk_off*WORD_W +: WORD_W];
        if (!vld[0][lk_idx])      vic_way = 1'b0;
        else if (!vld[1][lk_idx]) vic_way = 1'b1;
        else                      vic_way = lru[lk_idx];
        vic_dirty = vld[vic_way][lk_idx] && dty[vic_way][lk_idx];
        vic_tag   = tags[vic_way][lk_idx];
        vic_line  = lines[vic_way][lk_idx];
    end

    // control bits: valid, dirty, LRU
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NWAY; w++) begin
                vld[w] <= '0;
                dty[w] <= '0;
            end
            lru <= '0;
        end else begin
            case (act)
                ACT_HIT: begin
                    lru[lk_idx] <= ~lk_way;
                    if (wr_en) dty[lk_way][lk_idx] <= 1'b1;
                end
                ACT_EVICT: begin
                    vld[vic_way][lk_idx] <= 1'b0;
                    dty[vic_way][lk_idx] <= 1'b0;
                end
                ACT_ISSUE: lru[lk_idx] <= ~lru[lk_idx];
                ACT_FILL: begin
                    vld[fl_way][fl_idx] <= 1'b1;
                    dty[fl_way][fl_idx] <= fl_dirty;
                end
                default: ;
            endcase
        end
    end

    // tag and data arrays, no reset
    always_ff @(posedge clk) begin
        if (act == ACT_HIT && wr_en)
            lines[lk_way][lk_idx][lk_off*WORD_W +: WORD_W] <= wr_data;
        if (act == ACT_FILL) begin
            tags[fl_way][fl_idx]  <= fl_tag;
            lines[fl_way][fl_idx] <= fl_line;
        end
    end

endmodule

// File: rtl/wb2way_cache.sv
module wb2way_cache
    import wb2way_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int WORD_W   = 16,
    parameter int OFF_W    = 2,
    parameter int IDX_W    = 3,
    parameter int MQ_DEPTH = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cpu_req_valid,
    input  logic                        cpu_req_write,
    input  logic [ADDR_W-1:0]           cpu_req_addr,
    input  logic [WORD_W-1:0]           cpu_req_wdata,
    output logic                        cpu_req_accept,
    output logic                        cpu_resp_valid,
    output logic [WORD_W-1:0]           cpu_resp_data,
    output logic                        mem_req_valid,
    output logic                        mem_req_write,
    output logic [ADDR_W-1:0]           mem_req_addr,
    output logic [(WORD_W<<OFF_W)-1:0]  mem_req_line,
    input  logic                        mem_req_ready,
    input  logic                        mem_resp_valid,
    input  logic [(WORD_W<<OFF_W)-1:0]  mem_resp_line,
    output logic                        mem_resp_take
);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = WORD_W << OFF_W;

    typedef struct packed {
        logic              way;
        logic [IDX_W-1:0]  idx;
        logic [TAG_W-1:0]  tag;
        logic [OFF_W-1:0]  off;
        logic              write;
        logic [WORD_W-1:0] wdata;
    } mq_ent_t;

    localparam int ENT_W = $bits(mq_ent_t);

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [OFF_W-1:0]  req_off;
    logic              lk_hit, lk_way, vic_way, vic_dirty;
    logic [WORD_W-1:0] lk_word;
    logic [TAG_W-1:0]  vic_tag;
    logic [LINE_W-1:0] vic_line, fill_line;
    logic              q_full, q_empty;
    logic [ENT_W-1:0]  q_head_bits;
    mq_ent_t           q_head, q_new;
    act_e              act;

    assign req_tag = cpu_req_addr[ADDR_W-1 -: TAG_W];
    assign req_idx = cpu_req_addr[OFF_W +: IDX_W];
    assign req_off = cpu_req_addr[OFF_W-1:0];
    assign q_head  = mq_ent_t'(q_head_bits);

    always_comb begin
        q_new       = '0;
        q_new.way   = vic_way;
        q_new.idx   = req_idx;
        q_new.tag   = req_tag;
        q_new.off   = req_off;
        q_new.write = cpu_req_write;
        q_new.wdata = cpu_req_wdata;
    end

    // action selection, priority HIT > EVICT > ISSUE > FILL
    always_comb begin
        act = ACT_IDLE;
        if (cpu_req_valid && lk_hit)
            act = ACT_HIT;
        else if (cpu_req_valid && vic_dirty && mem_req_ready)
            act = ACT_EVICT;
        else if (cpu_req_valid && !vic_dirty && mem_req_ready && !q_full)
            act = ACT_ISSUE;
        else if (mem_resp_valid && !q_empty)
            act = ACT_FILL;
    end

    // store word merged into the fetched line on a store miss
    always_comb begin
        fill_line = mem_resp_line;
        if (q_head.write)
            fill_line[q_head.off*WORD_W +: WORD_W] = q_head.wdata;
    end

    // outputs of the chosen action
    always_comb begin
        cpu_req_accept = 1'b0;
        cpu_resp_valid = 1'b0;
        cpu_resp_data  = '0;
        mem_req_valid  = 1'b0;
        mem_req_write  = 1'b0;
        mem_req_addr   = '0;
        mem_req_line   = '0;
        mem_resp_take  = 1'b0;
        unique case (act)
            ACT_IDLE: ;
            ACT_HIT: begin
                cpu_req_accept = 1'b1;
                cpu_resp_valid = !cpu_req_write;
                cpu_resp_data  = lk_word;
            end
            ACT_EVICT: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = {vic_tag, req_idx, {OFF_W{1'b0}}};
                mem_req_line  = vic_line;
            end
            ACT_ISSUE: begin
                cpu_req_accept = 1'b1;
                mem_req_valid  = 1'b1;
                mem_req_addr   = {req_tag, req_idx, {OFF_W{1'b0}}};
            end
            ACT_FILL: begin
                mem_resp_take  = 1'b1;
                cpu_resp_valid = !q_head.write;
                cpu_resp_data  = mem_resp_line[q_head.off*WORD_W +: WORD_W];
            end
        endcase
    end

    wb2way_store #(
        .TAG_W (TAG_W),
        .IDX_W (IDX_W),
        .OFF_W (OFF_W),
        .WORD_W(WORD_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_tag   (req_tag),
        .lk_idx   (req_idx),
        .lk_off   (req_off),
        .lk_hit   (lk_hit),
        .lk_way   (lk_way),
        .lk_word  (lk_word),
        .vic_way  (vic_way),
        .vic_dirty(vic_dirty),
        .vic_tag  (vic_tag),
        .vic_line (vic_line),
        .act      (act),
        .wr_en    (cpu_req_write),
        .wr_data  (cpu_req_wdata),
        .fl_way   (q_head.way),
        .fl_idx   (q_head.idx),
        .fl_tag   (q_head.tag),
        .fl_line  (fill_line),
        .fl_dirty (q_head.write)
    );

    wb2way_missq #(
        .DEPTH(MQ_DEPTH),
        .ENT_W(ENT_W)
    ) u_missq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (act == ACT_ISSUE),
        .push_data(q_new),
        .pop      (act == ACT_FILL),
        .head     (q_head_bits),
        .full     (q_full),
        .empty    (q_empty)
    );

endmodule

// File: rtl/wb2way_cache_chk.sv
module wb2way_cache_chk #(
    parameter int ADDR_W   = 12,
    parameter int OFF_W    = 2,
    parameter int MQ_DEPTH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_valid,
    input logic              cpu_req_write,
    input logic              cpu_req_accept,
    input logic              cpu_resp_valid,
    input logic              mem_req_valid,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_req_ready,
    input logic              mem_resp_valid,
    input logic              mem_resp_take
);
    int pend_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_cnt <= 0;
        else
            pend_cnt <= pend_cnt + ((cpu_req_accept && mem_req_valid) ? 1 : 0)
                                 - (mem_resp_take ? 1 : 0);
    end

    // R2
    accept_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_accept |-> cpu_req_valid);

    // R4
    no_req_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_ready);

    // R4
    miss_sends_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_accept && mem_req_valid) |-> !mem_req_write);

    // R5
    evict_rejects_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> !cpu_req_accept);

    // R5
    line_aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));

    // R8
    take_needs_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_resp_take |-> (mem_resp_valid && pend_cnt > 0));

    // R9
    resp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp_valid |-> ((cpu_req_accept && !cpu_req_write && !mem_req_valid) || mem_resp_take));

    // R10
    one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_resp_take |-> (!cpu_req_accept && !mem_req_valid));

    // R11
    queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt <= MQ_DEPTH);

endmodule

bind wb2way_cache wb2way_cache_chk #(
    .ADDR_W  (ADDR_W),
    .OFF_W   (OFF_W),
    .MQ_DEPTH(MQ_DEPTH)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_write (cpu_req_write),
    .cpu_req_accept(cpu_req_accept),
    .cpu_resp_valid(cpu_resp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_ready (mem_req_ready),
    .mem_resp_valid(mem_resp_valid),
    .mem_resp_take (mem_resp_take)
);

// File: tb/wb2way_cache_test.sv
`timescale 1ns/1ps
module wb2way_cache_test;
    localparam int AW = 12, WW = 16, OW = 2, IW = 3, LW = WW << OW;

    logic clk = 0, rst_n = 0;
    logic cpu_req_valid = 0, cpu_req_write = 0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [WW-1:0] cpu_req_wdata = '0;
    logic cpu_req_accept, cpu_resp_valid;
    logic [WW-1:0] cpu_resp_data;
    logic mem_req_valid, mem_req_write, mem_resp_take;
    logic [AW-1:0] mem_req_addr;
    logic [LW-1:0] mem_req_line;
    logic mem_req_ready = 1, mem_resp_valid = 0;
    logic [LW-1:0] mem_resp_line = '0;

    always #4 clk = ~clk;

    wb2way_cache #(.ADDR_W(AW), .WORD_W(WW), .OFF_W(OW), .IDX_W(IW), .MQ_DEPTH(2)) uut (.*);

    int n_chk = 0, n_fail = 0, cyc = 0;
    int wb_count = 0, ld_count = 0;
    logic [AW-1:0] last_wb_addr = '0, last_ld_addr = '0;
    bit hold = 0;
    logic [WW-1:0] gold [int];
    logic [WW-1:0] pmem [int];
    logic [WW-1:0] exp_q [$];
    typedef struct { logic [LW-1:0] line; int due; } rsp_t;
    rsp_t rq [$];

    function automatic logic [AW-1:0] A(int t, int i, int o);
        return {t[AW-IW-OW-1:0], i[IW-1:0], o[OW-1:0]};
    endfunction
    function automatic logic [WW-1:0] init_word(logic [AW-1:0] a);
        return {4'hC, a} ^ 16'h0F0F;
    endfunction
    function automatic logic [WW-1:0] gget(logic [AW-1:0] a);
        return gold.exists(int'(a)) ? gold[int'(a)] : init_word(a);
    endfunction
    function automatic logic [WW-1:0] pget(logic [AW-1:0] a);
        return pmem.exists(int'(a)) ? pmem[int'(a)] : init_word(a);
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // memory model: in-order line loads, whole-line writebacks
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (mem_req_valid) begin
                if (mem_req_write) begin
                    wb_count++;
                    last_wb_addr = mem_req_addr;
                    for (int w = 0; w < (1 << OW); w++)
                        pmem[int'(mem_req_addr) + w] = mem_req_line[w*WW +: WW];
                end else begin
                    rsp_t r;
                    ld_count++;
                    last_ld_addr = mem_req_addr;
                    for (int w = 0; w < (1 << OW); w++)
                        r.line[w*WW +: WW] = pget(mem_req_addr + AW'(w));
                    r.due = cyc + 3;
                    rq.push_back(r);
                end
            end
            if (mem_resp_take && rq.size() > 0) void'(rq.pop_front());
        end
        @(posedge clk); #1;
        mem_resp_valid = !hold && rq.size() > 0 && rq[0].due <= cyc;
        mem_resp_line  = (rq.size() > 0) ? rq[0].line : '0;
    end

    // scoreboard monitor
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (cpu_req_valid && cpu_req_accept) begin
                if (cpu_req_write) begin
                    check(!cpu_resp_valid, "R3 store gives no response", 64'(cpu_resp_valid), 0);
                    gold[int'(cpu_req_addr)] = cpu_req_wdata;
                end else if (!mem_req_valid) begin
                    check(cpu_resp_valid && cpu_resp_data == gget(cpu_req_addr), "R2 hit data",
                          64'(cpu_resp_data), 64'(gget(cpu_req_addr)));
                end else begin
                    check(!cpu_resp_valid, "R4 miss issue gives no response", 64'(cpu_resp_valid), 0);
                    exp_q.push_back(gget(cpu_req_addr));
                end
            end else if (cpu_resp_valid) begin
                if (exp_q.size() == 0)
                    check(0, "R9 unexpected response", 64'(cpu_resp_data), 0);
                else begin
                    logic [WW-1:0] e;
                    e = exp_q.pop_front();
                    check(cpu_resp_data == e, "R9/R11 fill data in order", 64'(cpu_resp_data), 64'(e));
                end
            end
        end
    end

    task automatic req(bit wr, logic [AW-1:0] a, logic [WW-1:0] d, output bit hit, output int tries);
        @(posedge clk); #1;
        cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = d;
        hit = 0; tries = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            tries++;
            if (cpu_req_accept) begin
                hit = !mem_req_valid;
                break;
            end
        end
        @(posedge clk); #1;
        cpu_req_valid = 0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && rq.size() == 0) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        bit h;
        int t, wb0, ld0;
        // R1 reset state
        repeat (3) @(negedge clk);
        check(!cpu_resp_valid && !mem_req_valid && !mem_resp_take, "R1 outputs idle in reset",
              {61'd0, cpu_resp_valid, mem_req_valid, mem_resp_take}, 0);
        @(posedge clk); #1 rst_n = 1;

        // R1 R4 first load misses, line-aligned load
        ld0 = ld_count;
        req(0, A(1,0,2), 0, h, t);
        check(!h, "R1 first load misses", 64'(h), 0);
        check(ld_count == ld0 + 1 && last_ld_addr == A(1,0,0), "R4 load address aligned",
              64'(last_ld_addr), 64'(A(1,0,0)));
        wait_idle();

        // R2 hits
        req(0, A(1,0,3), 0, h, t);
        check(h, "R2 hit after fill", 64'(h), 1);
        req(0, A(1,0,0), 0, h, t);
        check(h, "R2 second hit", 64'(h), 1);

        // R6 R7 victim and LRU in set 0
        req(0, A(2,0,1), 0, h, t);
        check(!h, "R6 fills invalid way", 64'(h), 0);
        wait_idle();
        req(0, A(1,0,1), 0, h, t);
        check(h, "R7 hit way0", 64'(h), 1);
        wb0 = wb_count;
        req(0, A(3,0,0), 0, h, t);
        wait_idle();
        check(wb_count == wb0, "R6 clean victim no writeback", 64'(wb_count), 64'(wb0));
        req(0, A(1,0,2), 0, h, t);
        check(h, "R7 recently used line kept", 64'(h), 1);
        req(0, A(2,0,0), 0, h, t);
        check(!h, "R6 LRU way replaced", 64'(h), 0);
        wait_idle();

        // R8 R5 store miss merge, dirty eviction
        req(1, A(1,1,2), 16'hBEEF, h, t);
        check(!h, "R8 store miss", 64'(h), 0);
        wait_idle();
        req(0, A(1,1,2), 0, h, t);
        check(h, "R8 merged store word hits", 64'(h), 1);
        req(0, A(2,1,0), 0, h, t);
        wait_idle();
        wb0 = wb_count;
        req(0, A(3,1,0), 0, h, t);
        check(t == 2, "R5 dirty miss rejected once then accepted", 64'(t), 2);
        check(wb_count == wb0 + 1 && last_wb_addr == A(1,1,0), "R5 writeback address",
              64'(last_wb_addr), 64'(A(1,1,0)));
        check(pget(A(1,1,2)) == 16'hBEEF, "R5 writeback line data", 64'(pget(A(1,1,2))), 64'hBEEF);
        wait_idle();
        req(0, A(1,1,2), 0, h, t);
        check(!h, "R5 evicted line misses", 64'(h), 0);
        wait_idle();

        // R4 memory not ready
        @(posedge clk); #1;
        mem_req_ready = 0;
        cpu_req_valid = 1; cpu_req_write = 0; cpu_req_addr = A(5,2,0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(!cpu_req_accept && !mem_req_valid, "R4 miss waits for memory room",
                  {62'd0, cpu_req_accept, mem_req_valid}, 0);
        end
        @(posedge clk); #1 mem_req_ready = 1;
        @(negedge clk);
        check(cpu_req_accept, "R4 miss accepted once ready", 64'(cpu_req_accept), 1);
        @(posedge clk); #1 cpu_req_valid = 0;
        wait_idle();
        @(posedge clk); #1 mem_req_ready = 0;
        req(0, A(1,0,2), 0, h, t);
        check(h, "R2 hit with memory not ready", 64'(h), 1);
        mem_req_ready = 1;

        // R11 queue full
        hold = 1;
        req(0, A(1,3,0), 0, h, t);
        req(0, A(1,4,1), 0, h, t);
        @(posedge clk); #1;
        cpu_req_valid = 1; cpu_req_write = 0; cpu_req_addr = A(1,5,3);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(!cpu_req_accept, "R11 third miss rejected", 64'(cpu_req_accept), 0);
        end
        hold = 0;
        t = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (cpu_req_accept) begin t = 1; break; end
        end
        check(t == 1, "R11 accepted after a fill", 64'(t), 1);
        @(posedge clk); #1 cpu_req_valid = 0;
        wait_idle();

        // R10 hit outranks fill
        hold = 1;
        req(0, A(1,6,1), 0, h, t);
        repeat (6) @(negedge clk);
        hold = 0;
        @(posedge clk); #1;
        cpu_req_valid = 1; cpu_req_write = 0; cpu_req_addr = A(1,0,2);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            check(cpu_req_accept && !mem_resp_take && mem_resp_valid, "R10 hit before fill",
                  {61'd0, cpu_req_accept, mem_resp_take, mem_resp_valid}, 64'h5);
        end
        @(posedge clk); #1 cpu_req_valid = 0;
        @(negedge clk);
        check(mem_resp_take, "R10 fill after hits", 64'(mem_resp_take), 1);
        wait_idle();

        // R3 store hit marks dirty, eviction carries it
        req(1, A(1,0,3), 16'h5555, h, t);
        check(h, "R3 store hit", 64'(h), 1);
        req(0, A(1,0,3), 0, h, t);
        check(h, "R3 load after store hit", 64'(h), 1);
        req(0, A(4,0,0), 0, h, t);
        wait_idle();
        wb0 = wb_count;
        req(0, A(5,0,0), 0, h, t);
        check(wb_count == wb0 + 1 && last_wb_addr == A(1,0,0), "R3 dirty line written back",
              64'(last_wb_addr), 64'(A(1,0,0)));
        check(pget(A(1,0,3)) == 16'h5555, "R3 stored word in memory", 64'(pget(A(1,0,3))), 64'h5555);
        wait_idle();

        check(exp_q.size() == 0, "R9 all fills returned", 64'(exp_q.size()), 0);
        finish_run();
    end
endmodule